// File: doc/BRIEF.md
# Two-Port Synchronous Word Store with Burst Address Counters

This block is a shared word memory with two symmetric access ports, called left and right. Both ports share one clock. In every cycle each port may read or write any word, and this includes the word the other port is using. Each port captures its address, controls and write data in registers on the rising edge. It then performs the access in the cycle that follows.

Each port keeps its own address counter. A port can therefore walk through consecutive words while it presents a start address only once. The counter can be cleared, loaded from the external address, stepped, or held. A single mode input selects when read data appears. In flow-through mode it appears right after the sampling edge. In pipelined mode it appears one clock later, from an extra output register.

Each port has two chip selects and two byte-half write enables. An output enable acts at once on that port's read-valid flag. Depth and word width are parameters.

Top module: `dpram_burst`

## Requirements
- R1: After reset, both `*_rvalid` outputs are 0 and both `*_rdata` outputs are 0. Both address counters are 0, so a port that has not loaded an address accesses word 0.
- R2: With `pipe_mode`=0, a read is sampled at rising edge k. Its word is driven on `*_rdata` with `*_rvalid`=1 from edge k until edge k+1.
- R3: With `pipe_mode`=1, the same read is delivered from edge k+1 until edge k+2.
- R4: A port is selected only when `*_sel_n`=0 and `*_sel`=1. A deselected port writes nothing and its `*_rvalid` stays 0.
- R5: The byte-half enables are active low. `*_hi_n`=0 enables bits [DATA_W-1:DATA_W/2] and `*_lo_n`=0 enables bits [DATA_W/2-1:0]. A write changes only the enabled halves; with both enables high it changes nothing.
- R6: Counter controls are active low and follow a fixed priority. `*_clr_n` (word 0) comes first, then `*_ld_n` (external address), then `*_inc_n` (counter+1), then hold. On load the access uses the external address. On hold or increment the external address is ignored. The access address becomes the new counter value.
- R7: Incrementing from the last word wraps to word 0.
- R8: A clear takes no extra cycle: the read or write sampled with `*_clr_n`=0 accesses word 0.
- R9: When both ports write the same word in the same cycle, the stored word is the left port's write and the right port's write is discarded.
- R10: A read of a word that the other port writes in the same cycle returns the previous contents. The next read returns the new contents.
- R11: While `*_oe_n`=1, that port's `*_rvalid` and `*_rdata` are 0 in the same cycle, without waiting for a clock edge.
- R12: A write cycle produces no read data: `*_rvalid` is 0 in the slot where a read would have delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 0 selects flow-through reads, 1 selects pipelined reads |
| l_sel_n | input | 1 | Left chip select, active low |
| l_sel | input | 1 | Left chip select, active high |
| l_we_n | input | 1 | Left write (0) or read (1) |
| l_hi_n | input | 1 | Left upper-half write enable, active low |
| l_lo_n | input | 1 | Left lower-half write enable, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left external address |
| l_ld_n | input | 1 | Left counter load, active low |
| l_inc_n | input | 1 | Left counter increment, active low |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| r_sel_n | input | 1 | Right chip select, active low |
| r_sel | input | 1 | Right chip select, active high |
| r_we_n | input | 1 | Right write (0) or read (1) |
| r_hi_n | input | 1 | Right upper-half write enable, active low |
| r_lo_n | input | 1 | Right lower-half write enable, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right external address |
| r_ld_n | input | 1 | Right counter load, active low |
| r_inc_n | input | 1 | Right counter increment, active low |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid |

## Verification
A counter that holds a wrong value surfaces on the first read that relies on hold or increment. That read returns a neighbouring word one or two edges later, depending on the mode. The bench therefore fills the whole store through a burst and reads it back through counters rather than fresh loads. A wrong collision or byte-merge result remains hidden in the array until that word is read again, so every write in the bench is followed soon after by a read of the same word. A slip in latency moves every delivered word by one slot, so the scoreboard matches each expected word to an exact cycle.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_INCR  = 2'd1,
    CNT_LOAD  = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_e;

  // Priority: clear, then load, then increment, then hold.
  function automatic cnt_op_e decode_cnt(input logic clr_n, input logic ld_n, input logic inc_n);
    if (!clr_n)      return CNT_CLEAR;
    else if (!ld_n)  return CNT_LOAD;
    else if (!inc_n) return CNT_INCR;
    return CNT_HOLD;
  endfunction

endpackage

// File: rtl/dpb_port.sv
module dpb_port
  import dpb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          sel,
  input  logic          we_n,
  input  logic          hi_n,
  input  logic          lo_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          ld_n,
  input  logic          inc_n,
  input  logic          clr_n,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] acc_addr,
  output logic          rd_ev,
  output logic          wr_ev,
  output logic [1:0]    bmask,
  output logic [DW-1:0] wdata_q
);

  logic          sel_q;
  logic          wr_q;
  logic [1:0]    bmask_q;
  logic [AW-1:0] addr_q;
  cnt_op_e       op_q;
  logic [AW-1:0] cnt_q;

  function automatic logic [AW-1:0] next_addr(input cnt_op_e op, input logic [AW-1:0] ext,
                                               input logic [AW-1:0] cur);
    case (op)
      CNT_CLEAR: return '0;
      CNT_LOAD:  return ext;
      CNT_INCR:  return cur + 1'b1;
      default:   return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      wr_q    <= 1'b0;
      bmask_q <= 2'b00;
      addr_q  <= '0;
      op_q    <= CNT_HOLD;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      sel_q   <= !sel_n && sel;
      wr_q    <= !we_n;
      bmask_q <= {!hi_n, !lo_n};
      addr_q  <= ext_addr;
      op_q    <= decode_cnt(clr_n, ld_n, inc_n);
      wdata_q <= wdata;
      cnt_q   <= acc_addr;
    end
  end

  assign acc_addr = next_addr(op_q, addr_q, cnt_q);
  assign rd_ev    = sel_q && !wr_q;
  assign wr_ev    = sel_q && wr_q;
  assign bmask    = bmask_q;

  // Named events for the checks below
  logic ev_clear, ev_load, ev_incr, ev_hold;
  assign ev_clear = (op_q == CNT_CLEAR);
  assign ev_load  = (op_q == CNT_LOAD);
  assign ev_incr  = (op_q == CNT_INCR);
  assign ev_hold  = (op_q == CNT_HOLD);

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (cnt_q == '0));
  assert_load_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> (cnt_q == $past(addr_q)));
  assert_incr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_incr |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $stable(cnt_q));

endmodule

// File: rtl/dpb_rdout.sv
module dpb_rdout #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe,
  input  logic          oe_n,
  input  logic          rd_ev,
  input  logic          wr_ev,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);

  logic          pv_q;
  logic [DW-1:0] pd_q;
  logic          raw_v;
  logic [DW-1:0] raw_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else begin
      pv_q <= rd_ev;
      pd_q <= word;
    end
  end

  assign raw_v  = pipe ? pv_q : rd_ev;
  assign raw_d  = pipe ? pd_q : word;
  assign rvalid = raw_v && !oe_n;
  assign rdata  = rvalid ? raw_d : '0;

  assert_write_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && !pipe) |-> !rvalid);
  assert_pipe_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe && rd_ev) |=> (!pipe || oe_n || (rvalid && rdata == $past(word))));
  assert_flow_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe && !rd_ev) |-> !rvalid);

endmodule

// File: rtl/dpram_burst.sv
module dpram_burst
  import dpb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              l_sel_n,
  input  logic              l_sel,
  input  logic              l_we_n,
  input  logic              l_hi_n,
  input  logic              l_lo_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_ld_n,
  input  logic              l_inc_n,
  input  logic              l_clr_n,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  input  logic              r_sel_n,
  input  logic              r_sel,
  input  logic              r_we_n,
  input  logic              r_hi_n,
  input  logic              r_lo_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_ld_n,
  input  logic              r_inc_n,
  input  logic              r_clr_n,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DATA_W / 2;
  localparam int NPORT = 2;

  // Index 0 is the left port, index 1 the right port.
  logic              p_sel_n [NPORT];
  logic              p_sel   [NPORT];
  logic              p_we_n  [NPORT];
  logic              p_hi_n  [NPORT];
  logic              p_lo_n  [NPORT];
  logic              p_oe_n  [NPORT];
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic              p_ld_n  [NPORT];
  logic              p_inc_n [NPORT];
  logic              p_clr_n [NPORT];
  logic [DATA_W-1:0] p_wdata [NPORT];
  logic [DATA_W-1:0] p_rdata [NPORT];
  logic              p_rvld  [NPORT];

  logic [ADDR_W-1:0] acc     [NPORT];
  logic              rd_ev   [NPORT];
  logic              wr_ev   [NPORT];
  logic [1:0]        bmask   [NPORT];
  logic [DATA_W-1:0] wd_q    [NPORT];
  logic [DATA_W-1:0] rd_word [NPORT];
  logic [DATA_W-1:0] wword   [NPORT];

  logic [DATA_W-1:0] mem [DEPTH];

  assign p_sel_n[0] = l_sel_n;  assign p_sel_n[1] = r_sel_n;
  assign p_sel[0]   = l_sel;    assign p_sel[1]   = r_sel;
  assign p_we_n[0]  = l_we_n;   assign p_we_n[1]  = r_we_n;
  assign p_hi_n[0]  = l_hi_n;   assign p_hi_n[1]  = r_hi_n;
  assign p_lo_n[0]  = l_lo_n;   assign p_lo_n[1]  = r_lo_n;
  assign p_oe_n[0]  = l_oe_n;   assign p_oe_n[1]  = r_oe_n;
  assign p_addr[0]  = l_addr;   assign p_addr[1]  = r_addr;
  assign p_ld_n[0]  = l_ld_n;   assign p_ld_n[1]  = r_ld_n;
  assign p_inc_n[0] = l_inc_n;  assign p_inc_n[1] = r_inc_n;
  assign p_clr_n[0] = l_clr_n;  assign p_clr_n[1] = r_clr_n;
  assign p_wdata[0] = l_wdata;  assign p_wdata[1] = r_wdata;
  assign l_rdata    = p_rdata[0];
  assign l_rvalid   = p_rvld[0];
  assign r_rdata    = p_rdata[1];
  assign r_rvalid   = p_rvld[1];

  // Byte-half merge: bit 1 of be enables the upper half, bit 0 the lower.
  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [1:0] be);
    logic [DATA_W-1:0] res;
    res = old_w;
    if (be[0]) res[HALF-1:0] = new_w[HALF-1:0];
    if (be[1]) res[DATA_W-1:HALF] = new_w[DATA_W-1:HALF];
    return res;
  endfunction

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dpb_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_n    (p_sel_n[g]),
      .sel      (p_sel[g]),
      .we_n     (p_we_n[g]),
      .hi_n     (p_hi_n[g]),
      .lo_n     (p_lo_n[g]),
      .ext_addr (p_addr[g]),
      .ld_n     (p_ld_n[g]),
      .inc_n    (p_inc_n[g]),
      .clr_n    (p_clr_n[g]),
      .wdata    (p_wdata[g]),
      .acc_addr (acc[g]),
      .rd_ev    (rd_ev[g]),
      .wr_ev    (wr_ev[g]),
      .bmask    (bmask[g]),
      .wdata_q  (wd_q[g])
    );

    assign rd_word[g] = mem[acc[g]];
    assign wword[g]   = merge_word(mem[acc[g]], wd_q[g], bmask[g]);

    dpb_rdout #(.DW(DATA_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .pipe   (pipe_mode),
      .oe_n   (p_oe_n[g]),
      .rd_ev  (rd_ev[g]),
      .wr_ev  (wr_ev[g]),
      .word   (rd_word[g]),
      .rdata  (p_rdata[g]),
      .rvalid (p_rvld[g])
    );
  end

  // Same-word collision: the left port's write is kept.
  logic clash;
  assign clash = wr_ev[0] && wr_ev[1] && (acc[0] == acc[1]);

  always_ff @(posedge clk) begin
    if (wr_ev[1] && !clash) mem[acc[1]] <= wword[1];
    if (wr_ev[0])           mem[acc[0]] <= wword[0];
  end

  assert_left_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> (mem[$past(acc[0])] == $past(wword[0])));

endmodule

// File: tb/dpram_burst_test.sv
module dpram_burst_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DW    = 18;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DW / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b0;
  logic l_sel_n = 1'b1, l_sel = 1'b0, l_we_n = 1'b1, l_hi_n = 1'b1, l_lo_n = 1'b1, l_oe_n = 1'b0;
  logic l_ld_n = 1'b1, l_inc_n = 1'b1, l_clr_n = 1'b1;
  logic [AW-1:0] l_addr = '0;
  logic [DW-1:0] l_wdata = '0;
  logic [DW-1:0] l_rdata;
  logic l_rvalid;
  logic r_sel_n = 1'b1, r_sel = 1'b0, r_we_n = 1'b1, r_hi_n = 1'b1, r_lo_n = 1'b1, r_oe_n = 1'b0;
  logic r_ld_n = 1'b1, r_inc_n = 1'b1, r_clr_n = 1'b1;
  logic [AW-1:0] r_addr = '0;
  logic [DW-1:0] r_wdata = '0;
  logic [DW-1:0] r_rdata;
  logic r_rvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_burst #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .l_sel_n(l_sel_n), .l_sel(l_sel), .l_we_n(l_we_n), .l_hi_n(l_hi_n), .l_lo_n(l_lo_n),
    .l_oe_n(l_oe_n), .l_addr(l_addr), .l_ld_n(l_ld_n), .l_inc_n(l_inc_n), .l_clr_n(l_clr_n),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_sel_n(r_sel_n), .r_sel(r_sel), .r_we_n(r_we_n), .r_hi_n(r_hi_n), .r_lo_n(r_lo_n),
    .r_oe_n(r_oe_n), .r_addr(r_addr), .r_ld_n(r_ld_n), .r_inc_n(r_inc_n), .r_clr_n(r_clr_n),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  typedef struct {
    bit sa; bit sb; bit wr; bit hi; bit lo; bit clr; bit ld; bit inc;
    bit [AW-1:0] a; bit [DW-1:0] d;
  } op_t;

  typedef struct {
    int due; bit port; bit v; bit [DW-1:0] d; string tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  logic [DW-1:0] model [DEPTH];
  logic [AW-1:0] cnt_m [2];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit pipe_b = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic op_t op_idle();
    op_t o = '{default: 0};
    return o;
  endfunction

  function automatic op_t op_rd(bit clr, bit ld, bit inc, logic [AW-1:0] a);
    op_t o = '{default: 0};
    o.sa = 1; o.sb = 1; o.clr = clr; o.ld = ld; o.inc = inc; o.a = a;
    return o;
  endfunction

  function automatic op_t op_wr(bit clr, bit ld, bit inc, logic [AW-1:0] a, logic [DW-1:0] d,
                                bit hi, bit lo);
    op_t o = op_rd(clr, ld, inc, a);
    o.wr = 1; o.d = d; o.hi = hi; o.lo = lo;
    return o;
  endfunction

  // Bench view of the counter priority (R6, R7, R8)
  function automatic logic [AW-1:0] pick(op_t o, logic [AW-1:0] c);
    if (o.clr) return '0;
    if (o.ld)  return o.a;
    if (o.inc) return AW'(c + 1);
    return c;
  endfunction

  // Bench view of the byte-half merge (R5)
  function automatic logic [DW-1:0] blend(logic [DW-1:0] old_w, logic [DW-1:0] new_w, bit hi, bit lo);
    logic [DW-1:0] m;
    m = {{HALF{hi}}, {HALF{lo}}};
    return (old_w & ~m) | (new_w & m);
  endfunction

  function automatic logic [DW-1:0] fill_val(int i);
    return DW'(i * 1031 + 7);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive_port(int p, op_t o);
    if (p == 0) begin
      l_sel_n = !o.sa; l_sel = o.sb; l_we_n = !o.wr; l_hi_n = !o.hi; l_lo_n = !o.lo;
      l_clr_n = !o.clr; l_ld_n = !o.ld; l_inc_n = !o.inc; l_addr = o.a; l_wdata = o.d;
    end else begin
      r_sel_n = !o.sa; r_sel = o.sb; r_we_n = !o.wr; r_hi_n = !o.hi; r_lo_n = !o.lo;
      r_clr_n = !o.clr; r_ld_n = !o.ld; r_inc_n = !o.inc; r_addr = o.a; r_wdata = o.d;
    end
  endtask

  task automatic push(bit p, bit v, logic [DW-1:0] d, string tag);
    exp_t e;
    e.due = cyc + (pipe_b ? 2 : 1);
    e.port = p; e.v = v; e.d = v ? d : '0; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver: one operation per port per cycle, expected results into the queue
  task automatic step(op_t lo, op_t ro, string tag, bit oe_off_l = 0, bit oe_off_r = 0);
    logic [AW-1:0] a0, a1;
    bit act0, act1, w0, w1;
    @(negedge clk);
    drive_port(0, lo);
    drive_port(1, ro);
    l_oe_n = oe_off_l;
    r_oe_n = oe_off_r;
    a0 = pick(lo, cnt_m[0]);
    a1 = pick(ro, cnt_m[1]);
    act0 = lo.sa && lo.sb;
    act1 = ro.sa && ro.sb;
    push(0, act0 && !lo.wr, model[a0], tag);
    push(1, act1 && !ro.wr, model[a1], tag);
    w0 = act0 && lo.wr;
    w1 = act1 && ro.wr;
    if (w1 && !(w0 && a0 == a1)) model[a1] = blend(model[a1], ro.d, ro.hi, ro.lo);
    if (w0) model[a0] = blend(model[a0], lo.d, lo.hi, lo.lo);
    cnt_m[0] = a0;
    cnt_m[1] = a1;
  endtask

  task automatic drain();
    repeat (3) step(op_idle(), op_idle(), "R4");
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pop every item due in this cycle and compare
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      bit av, eo, ev;
      logic [DW-1:0] ad, ed;
      mon_e = q.pop_front();
      av = mon_e.port ? r_rvalid : l_rvalid;
      ad = mon_e.port ? r_rdata : l_rdata;
      eo = mon_e.port ? r_oe_n : l_oe_n;
      ev = mon_e.v && !eo;
      ed = ev ? mon_e.d : '0;
      check(mon_e.due == cyc && av == ev && ad == ed, mon_e.tag,
            mon_e.port ? "right {rvalid,rdata}" : "left {rvalid,rdata}",
            {av, ad}, {ev, ed});
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    op_t o;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    cnt_m[0] = '0;
    cnt_m[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: outputs idle after reset
    check(!l_rvalid && l_rdata == '0, "R1", "left after reset", {l_rvalid, l_rdata}, '0);
    check(!r_rvalid && r_rdata == '0, "R1", "right after reset", {r_rvalid, r_rdata}, '0);

    // R6: fill the store by load then increments; R7: one more step wraps to word 0
    step(op_wr(0, 1, 0, 0, fill_val(0), 1, 1), op_idle(), "R12");
    for (int i = 1; i < DEPTH; i++) step(op_wr(0, 0, 1, 0, fill_val(i), 1, 1), op_idle(), "R6");
    step(op_wr(0, 0, 1, 0, 18'h2A5A5, 1, 1), op_idle(), "R7");
    // R1: right counter untouched since reset, so hold reads word 0
    step(op_idle(), op_rd(0, 0, 0, 6'd17), "R1");

    // R2: flow-through bursts, right one wrapping (R7)
    step(op_rd(0, 1, 0, 6'd5), op_rd(0, 1, 0, 6'd62), "R2");
    repeat (3) step(op_rd(0, 0, 1, 0), op_rd(0, 0, 1, 0), "R7");

    // R6/R8: counter priority
    step(op_rd(1, 1, 1, 6'd9), op_idle(), "R8");
    step(op_rd(0, 1, 1, 6'd9), op_idle(), "R6");
    step(op_rd(0, 0, 1, 6'd33), op_idle(), "R6");
    step(op_rd(0, 0, 0, 6'd33), op_idle(), "R6");
    step(op_wr(1, 0, 0, 6'd7, 18'h11111, 1, 1), op_idle(), "R8");
    step(op_rd(0, 0, 0, 6'd7), op_idle(), "R8");

    // R5: byte-half writes
    step(op_wr(0, 1, 0, 6'd20, 18'h3FFFF, 1, 0), op_idle(), "R5");
    step(op_rd(0, 0, 0, 0), op_idle(), "R5");
    step(op_wr(0, 0, 0, 0, 18'h00000, 0, 1), op_idle(), "R5");
    step(op_rd(0, 0, 0, 0), op_idle(), "R5");
    step(op_wr(0, 0, 0, 0, 18'h12345, 0, 0), op_idle(), "R5");
    step(op_rd(0, 0, 0, 0), op_idle(), "R5");

    // R4: each chip select alone leaves the port deselected
    o = op_wr(0, 1, 0, 6'd21, 18'h3ABCD, 1, 1); o.sa = 0;
    step(o, op_idle(), "R4");
    o = op_wr(0, 1, 0, 6'd21, 18'h0BEEF, 1, 1); o.sb = 0;
    step(o, op_idle(), "R4");
    o = op_rd(0, 1, 0, 6'd21); o.sb = 0;
    step(o, op_idle(), "R4");
    step(op_rd(0, 1, 0, 6'd21), op_idle(), "R4");

    // R9: same-word collision, left wins
    step(op_wr(0, 1, 0, 6'd30, 18'h15555, 1, 0), op_wr(0, 1, 0, 6'd30, 18'h2AAAA, 1, 1), "R9");
    step(op_rd(0, 0, 0, 0), op_rd(0, 0, 0, 0), "R9");

    // R10: read during the other port's write
    step(op_wr(0, 1, 0, 6'd31, 18'h0F0F0, 1, 1), op_rd(0, 1, 0, 6'd31), "R10");
    step(op_idle(), op_rd(0, 0, 0, 0), "R10");

    // R11: output enable gates in the delivery cycle
    step(op_rd(0, 1, 0, 6'd5), op_rd(0, 1, 0, 6'd6), "R2");
    step(op_idle(), op_idle(), "R11", 1, 1);
    step(op_idle(), op_idle(), "R11");

    // R12: writes on both ports drive no read data
    step(op_wr(0, 1, 0, 6'd40, 18'h01234, 1, 1), op_wr(0, 1, 0, 6'd41, 18'h04321, 1, 1), "R12");
    step(op_rd(0, 1, 0, 6'd41), op_rd(0, 1, 0, 6'd40), "R2");

    // R3: pipelined mode
    drain();
    pipe_mode = 1'b1;
    pipe_b = 1;
    step(op_rd(0, 1, 0, 6'd5), op_rd(0, 1, 0, 6'd62), "R3");
    step(op_rd(0, 0, 1, 0), op_rd(0, 0, 1, 0), "R3");
    step(op_rd(0, 0, 1, 0), op_rd(0, 0, 1, 0), "R3");
    step(op_wr(0, 1, 0, 6'd44, 18'h12345, 1, 1), op_idle(), "R12");
    step(op_rd(0, 0, 0, 0), op_idle(), "R3");
    step(op_wr(0, 1, 0, 6'd45, 18'h3C3C3, 1, 1), op_rd(0, 1, 0, 6'd45), "R10");
    step(op_idle(), op_rd(0, 0, 0, 0), "R10");
    step(op_wr(0, 1, 0, 6'd46, 18'h00FF0, 0, 1), op_wr(0, 1, 0, 6'd46, 18'h3FFFF, 1, 1), "R9");
    step(op_rd(0, 0, 0, 0), op_rd(0, 0, 0, 0), "R9");
    step(op_rd(0, 1, 0, 6'd5), op_rd(0, 1, 0, 6'd6), "R3");
    step(op_idle(), op_idle(), "R3");
    step(op_idle(), op_idle(), "R11", 1, 0);
    step(op_idle(), op_idle(), "R11");
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule